// File: doc/BRIEF.md
# Two-Stage Fault Recovery Sequencer

This block sits in each node of a redundant memory interconnect and steers the node through recovery once hardware has detected an error. A detection strobe arrives with an error type code and the location of the module where the error was seen. The block answers by broadcasting an error report tagged with the node's own address. It then holds the node quiet for a programmable number of cycles so that a transient can die out, and after that asks for every outstanding access to be retried.

Recovery has two stages. If the retry completes without another error, the node simply returns to normal work. If the error comes back during the retry, the block sends a second report and quiets the node again. During that second quiet period it isolates the faulty module and brings its redundant partner into service. It then retries once more and raises a reconfiguration request to the attached processor. That request stays asserted until the processor acknowledges it.

Software can switch off automatic failover. With failover off, a recurring error parks the block in a sticky error state, and only a software clear releases it. The quiet-period length and the failover enable are configuration inputs that are set before normal operation.

Top module: `fault_recovery_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, every status output is low, both module vectors are zero, and `rpt_node_o` holds the value that `node_id_i` had during reset.
- R2: An error strobe seen while idle gives, one clock later, a single-cycle `rpt_valid_o` with `rpt_stage_o`=0, the strobe's type and location, and the node address. `quiesce_o` rises in that same cycle.
- R3: With `cfg_quiet_i`=N, `quiesce_o` stays high for exactly N+1 cycles. `retry_o` is high in the next cycle.
- R4: An error strobe during a quiet period produces no report. It restarts the wait, so `quiesce_o` stays high for N+1 cycles counted from the cycle after that strobe.
- R5: If `retry_done_i` is seen in the first retry with no error strobe in that cycle, the block returns to idle. No module is isolated and no reconfiguration request is raised.
- R6: An error strobe in the first retry with `cfg_failover_en_i`=1 gives, one clock later, a report with `rpt_stage_o`=1 carrying the new type and location. The second quiet period starts in that same cycle. If `retry_done_i` arrives in the same cycle as the strobe, the error wins.
- R7: When the second quiet period starts, bit L of `isolate_o` and bit L XOR 1 of `spare_on_o` are set, where L is the failing location. Both bits stay set until reset.
- R8: After the second quiet period, `retry_o` is high again. A `retry_done_i` then raises `reconf_req_o`, which stays high until `reconf_ack_i` is seen. The block is idle in the cycle after the acknowledge.
- R9: An error strobe in the first retry with `cfg_failover_en_i`=0 gives a stage-1 report and sets `sticky_err_o` with no quiet period and no isolation. `sticky_err_o` holds until `sw_clear_i` is seen, and the block is idle one cycle after the clear.
- R10: Error strobes are ignored while the sticky error is set, during the second retry, and while the reconfiguration request is pending. No report is produced in those states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous initialisation |
| node_id_i | input | 4 | Node address, captured during reset |
| cfg_quiet_i | input | 8 | Quiet-period length N (N+1 cycles) |
| cfg_failover_en_i | input | 1 | Enables automatic isolation and failover |
| err_det_i | input | 1 | Error detection strobe |
| err_type_i | input | 3 | Error type code |
| err_loc_i | input | 2 | Location of the failing module |
| retry_done_i | input | 1 | Outstanding accesses have been retried |
| reconf_ack_i | input | 1 | Processor acknowledges the reconfiguration request |
| sw_clear_i | input | 1 | Software clears the sticky error |
| rpt_valid_o | output | 1 | Error report strobe |
| rpt_stage_o | output | 1 | 0 = first report, 1 = recurrence |
| rpt_type_o | output | 3 | Reported error type |
| rpt_loc_o | output | 2 | Reported location |
| rpt_node_o | output | 4 | Reporting node address |
| quiesce_o | output | 1 | Node must stay quiet |
| retry_o | output | 1 | Retry outstanding accesses |
| reconf_req_o | output | 1 | Reconfiguration request to the processor |
| sticky_err_o | output | 1 | Recurring error while failover is disabled |
| isolate_o | output | 4 | Isolated modules, one bit per location |
| spare_on_o | output | 4 | Activated redundant partners, one bit per location |

## Verification
The assertions assume that `cfg_quiet_i` and `cfg_failover_en_i` stay constant while a recovery is in progress. They also assume that `retry_done_i`, `reconf_ack_i` and `sw_clear_i` are single-cycle pulses given only in the state that waits for them. The stimulus changes configuration only while reset is held, and pulses each handshake only after checking that the matching status output is high. Error strobes are deliberately also sent in states that must ignore them.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_QUIET1 = 3'd1,
        ST_RETRY1 = 3'd2,
        ST_QUIET2 = 3'd3,
        ST_RETRY2 = 3'd4,
        ST_NOTIFY = 3'd5,
        ST_HALT   = 3'd6
    } frs_state_e;

endpackage

// File: rtl/frs_quiet_timer.sv
module frs_quiet_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = limit_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3: the wait shrinks by one each running cycle
    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: a reload always restores the full limit
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(limit_i)));

endmodule

// File: rtl/frs_iso_map.sv
module frs_iso_map #(
    parameter int LOC_W = 2,
    localparam int NMOD = 1 << LOC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [LOC_W-1:0] loc_i,
    output logic [NMOD-1:0]  iso_o,
    output logic [NMOD-1:0]  spare_o
);

    logic [NMOD-1:0] iso_d, iso_q, spare_d, spare_q;

    for (genvar i = 0; i < NMOD; i++) begin : g_mod
        localparam logic [LOC_W-1:0] SELF    = LOC_W'(i);
        localparam logic [LOC_W-1:0] PARTNER = LOC_W'(i ^ 1);

        always_comb begin
            iso_d[i]   = iso_q[i]   | (set_i && loc_i == SELF);
            spare_d[i] = spare_q[i] | (set_i && loc_i == PARTNER);
        end

        // R7: once isolated, a module stays isolated
        a_r7_iso_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            iso_q[i] |=> iso_q[i]);
        a_r7_spare_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            spare_q[i] |=> spare_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iso_q   <= '0;
            spare_q <= '0;
        end else begin
            iso_q   <= iso_d;
            spare_q <= spare_d;
        end
    end

    assign iso_o   = iso_q;
    assign spare_o = spare_q;

endmodule

// File: rtl/fault_recovery_seq.sv
module fault_recovery_seq
    import frs_pkg::*;
#(
    parameter int LOC_W  = 2,
    parameter int TYPE_W = 3,
    parameter int NODE_W = 4,
    parameter int CNT_W  = 8,
    localparam int NMOD  = 1 << LOC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] node_id_i,
    input  logic [CNT_W-1:0]  cfg_quiet_i,
    input  logic              cfg_failover_en_i,
    input  logic              err_det_i,
    input  logic [TYPE_W-1:0] err_type_i,
    input  logic [LOC_W-1:0]  err_loc_i,
    input  logic              retry_done_i,
    input  logic              reconf_ack_i,
    input  logic              sw_clear_i,
    output logic              rpt_valid_o,
    output logic              rpt_stage_o,
    output logic [TYPE_W-1:0] rpt_type_o,
    output logic [LOC_W-1:0]  rpt_loc_o,
    output logic [NODE_W-1:0] rpt_node_o,
    output logic              quiesce_o,
    output logic              retry_o,
    output logic              reconf_req_o,
    output logic              sticky_err_o,
    output logic [NMOD-1:0]   isolate_o,
    output logic [NMOD-1:0]   spare_on_o
);

    typedef struct packed {
        frs_state_e        st;
        logic              rpt_v;
        logic              rpt_stage;
        logic [TYPE_W-1:0] typ;
        logic [LOC_W-1:0]  loc;
        logic [NODE_W-1:0] node;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_load, tmr_expired, tmr_run, iso_set;

    always_comb begin
        seq_d       = seq_q;
        seq_d.rpt_v = 1'b0;
        tmr_load    = 1'b0;
        iso_set     = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (err_det_i) begin
                    seq_d.st        = ST_QUIET1;
                    seq_d.rpt_v     = 1'b1;
                    seq_d.rpt_stage = 1'b0;
                    seq_d.typ       = err_type_i;
                    seq_d.loc       = err_loc_i;
                    tmr_load        = 1'b1;
                end
            end
            ST_QUIET1, ST_QUIET2: begin
                if (err_det_i) begin
                    tmr_load = 1'b1;
                end else if (tmr_expired) begin
                    seq_d.st = (seq_q.st == ST_QUIET1) ? ST_RETRY1 : ST_RETRY2;
                end
            end
            ST_RETRY1: begin
                if (err_det_i) begin
                    seq_d.rpt_v     = 1'b1;
                    seq_d.rpt_stage = 1'b1;
                    seq_d.typ       = err_type_i;
                    seq_d.loc       = err_loc_i;
                    if (cfg_failover_en_i) begin
                        seq_d.st = ST_QUIET2;
                        tmr_load = 1'b1;
                        iso_set  = 1'b1;
                    end else begin
                        seq_d.st = ST_HALT;
                    end
                end else if (retry_done_i) begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_RETRY2: begin
                if (retry_done_i) seq_d.st = ST_NOTIFY;
            end
            ST_NOTIFY: begin
                if (reconf_ack_i) seq_d.st = ST_IDLE;
            end
            ST_HALT: begin
                if (sw_clear_i) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.node <= node_id_i;
        end else begin
            seq_q      <= seq_d;
        end
    end

    assign tmr_run = (seq_q.st == ST_QUIET1) || (seq_q.st == ST_QUIET2);

    frs_quiet_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .run_i     (tmr_run),
        .limit_i   (cfg_quiet_i),
        .expired_o (tmr_expired)
    );

    frs_iso_map #(.LOC_W(LOC_W)) u_iso (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (iso_set),
        .loc_i   (err_loc_i),
        .iso_o   (isolate_o),
        .spare_o (spare_on_o)
    );

    assign rpt_valid_o  = seq_q.rpt_v;
    assign rpt_stage_o  = seq_q.rpt_stage;
    assign rpt_type_o   = seq_q.typ;
    assign rpt_loc_o    = seq_q.loc;
    assign rpt_node_o   = seq_q.node;
    assign quiesce_o    = tmr_run;
    assign retry_o      = (seq_q.st == ST_RETRY1) || (seq_q.st == ST_RETRY2);
    assign reconf_req_o = (seq_q.st == ST_NOTIFY);
    assign sticky_err_o = (seq_q.st == ST_HALT);

    // R2: a report always answers a strobe from the previous cycle
    a_r2_report_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o |-> $past(err_det_i));

    // R2: a quiet period only begins after an error strobe
    a_r2_quiet_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiesce_o) |-> $past(err_det_i));

    // R5: a clean first retry goes straight back to idle
    a_r5_clean_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RETRY1 && retry_done_i && !err_det_i) |=> (seq_q.st == ST_IDLE));

    // R8: the reconfiguration request is held until acknowledged
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req_o && !reconf_ack_i) |=> reconf_req_o);

    // R9: the sticky error holds until software clears it
    a_r9_sticky_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_err_o && !sw_clear_i) |=> sticky_err_o);

    // R10: no report while sticky, in second retry or awaiting acknowledge
    a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_err_o || reconf_req_o || seq_q.st == ST_RETRY2) |=> !rpt_valid_o);

endmodule

// File: tb/fault_recovery_seq_test.sv
module fault_recovery_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] node_id;
    logic [7:0] cfg_quiet;
    logic       cfg_fo;
    logic       err_det;
    logic [2:0] err_type;
    logic [1:0] err_loc;
    logic       retry_done, reconf_ack, sw_clear;
    logic       rpt_valid, rpt_stage, quiesce, retry, reconf_req, sticky;
    logic [2:0] rpt_type;
    logic [1:0] rpt_loc;
    logic [3:0] rpt_node, isolate, spare_on;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fault_recovery_seq uut (
        .clk(clk), .rst_n(rst_n), .node_id_i(node_id), .cfg_quiet_i(cfg_quiet),
        .cfg_failover_en_i(cfg_fo), .err_det_i(err_det), .err_type_i(err_type),
        .err_loc_i(err_loc), .retry_done_i(retry_done), .reconf_ack_i(reconf_ack),
        .sw_clear_i(sw_clear), .rpt_valid_o(rpt_valid), .rpt_stage_o(rpt_stage),
        .rpt_type_o(rpt_type), .rpt_loc_o(rpt_loc), .rpt_node_o(rpt_node),
        .quiesce_o(quiesce), .retry_o(retry), .reconf_req_o(reconf_req),
        .sticky_err_o(sticky), .isolate_o(isolate), .spare_on_o(spare_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] nid, input logic [7:0] q, input logic fo);
        rst_n = 1'b0; node_id = nid; cfg_quiet = q; cfg_fo = fo;
        err_det = 0; err_type = 0; err_loc = 0;
        retry_done = 0; reconf_ack = 0; sw_clear = 0;
        step(); step();
        node_id = ~nid;
        rst_n = 1'b1;
        step();
        // R1: reset state and captured node address
        chk("R1 status", {rpt_valid, quiesce, retry, reconf_req, sticky}, 0);
        chk("R1 vectors", {isolate, spare_on}, 0);
        chk("R1 node", rpt_node, nid);
    endtask

    task automatic strobe(input logic [2:0] t, input logic [1:0] l);
        err_det = 1; err_type = t; err_loc = l;
        step();
        err_det = 0;
    endtask

    task automatic count_quiet(output int n);
        n = 0;
        while (quiesce && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic run_case(input int q, input int mode, input logic [1:0] l, input logic [2:0] t);
        int n;
        logic [3:0] nid;
        logic [1:0] l2;
        nid = 4'(q * 3 + l + mode);
        l2  = l ^ 2'd2;
        do_reset(nid, 8'(q), mode != 2);
        strobe(t, l);
        // R2: first report
        chk("R2 valid", rpt_valid, 1);
        chk("R2 stage", rpt_stage, 0);
        chk("R2 type", rpt_type, t);
        chk("R2 loc", rpt_loc, l);
        chk("R2 node", rpt_node, nid);
        chk("R2 quiet", quiesce, 1);
        if (mode == 3 && q > 0) begin
            repeat (q) step();
            strobe(t ^ 3'd1, l2);
            // R4: extension without report
            chk("R4 no report", rpt_valid, 0);
            chk("R4 still quiet", quiesce, 1);
        end else begin
            step();
            chk("R2 single pulse", rpt_valid, 0);
        end
        count_quiet(n);
        chk("R3 quiet length", (mode == 3 && q > 0) ? n : n + 1, q + 1);
        chk("R3 retry", retry, 1);
        if (mode == 0 || mode == 3) begin
            retry_done = 1; step(); retry_done = 0;
            // R5: clean retry back to idle
            chk("R5 idle", {quiesce, retry, reconf_req, sticky}, 0);
            chk("R5 no isolation", {isolate, spare_on}, 0);
        end else if (mode == 1) begin
            retry_done = l[0];
            strobe(~t, l2);
            retry_done = 0;
            // R6: second report and second quiet
            chk("R6 valid", rpt_valid, 1);
            chk("R6 stage", rpt_stage, 1);
            chk("R6 type", rpt_type, 3'(~t));
            chk("R6 loc", rpt_loc, l2);
            chk("R6 quiet", quiesce, 1);
            // R7: isolation map
            chk("R7 isolate", isolate, 1 << l2);
            chk("R7 spare", spare_on, 1 << (l2 ^ 2'd1));
            count_quiet(n);
            chk("R3 second quiet length", n, q + 1);
            chk("R8 retry again", retry, 1);
            strobe(t, l);
            chk("R10 ignored in second retry", {rpt_valid, retry}, 1);
            retry_done = 1; step(); retry_done = 0;
            chk("R8 request", {reconf_req, retry}, 2);
            repeat (3) step();
            chk("R8 held", reconf_req, 1);
            strobe(t, l);
            chk("R10 ignored while pending", rpt_valid, 0);
            reconf_ack = 1; step(); reconf_ack = 0;
            chk("R8 idle after ack", {reconf_req, quiesce, retry}, 0);
            chk("R7 kept", isolate, 1 << l2);
        end else begin
            strobe(~t, l2);
            // R9: failover disabled
            chk("R9 report", {rpt_valid, rpt_stage}, 3);
            chk("R9 sticky", {sticky, quiesce, retry}, 4);
            chk("R9 no isolation", {isolate, spare_on}, 0);
            step();
            strobe(t, l);
            chk("R10 ignored while sticky", {rpt_valid, sticky}, 1);
            sw_clear = 1; step(); sw_clear = 0;
            chk("R9 cleared", {sticky, quiesce, retry}, 0);
        end
    endtask

    initial begin
        fork
            begin
                for (int q = 0; q < 4; q++)
                    for (int mode = 0; mode < 4; mode++)
                        for (int l = 0; l < 4; l++)
                            run_case(q, mode, 2'(l), 3'(q + 2 * l + mode));
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule